// File: doc/BRIEF.md
# Graded Spike Accumulate-and-Fire Unit

This block is the neuron-state engine of one event-driven core. Incoming 32-bit address-event packets carry an integer (graded) spike magnitude, a target neuron and a source slot. For each event the block finds the synaptic weight, multiplies it by the spike magnitude, and adds the signed product to the target neuron's 24-bit membrane state. Events wait in a small internal FIFO and are applied one per cycle.

A timestep strobe closes the accumulation window. New events are refused while queued events drain. Then every neuron is visited in ascending order. A neuron whose state reaches its threshold emits an outgoing graded spike. The spike carries the quotient of state over threshold, and that many thresholds are taken off its state. A configuration port loads weights, thresholds and per-neuron fan-in base addresses.

Top module: `spike_accum_core`

## Requirements
- R1: After reset every membrane state and every threshold is zero, `in_ready` is 1 and `out_valid` is 0. A strobe issued before any configuration produces no output spikes.
- R2: An accepted packet gives spike magnitude `in_pkt[11:0]` (unsigned), target neuron `in_pkt[12 +: ID_W]` and source slot `in_pkt[31:22]`. The weight used is at address (fan-in base of the target + source slot) modulo the weight depth. The target's state grows by magnitude × weight.
- R3: With `WMODE` = 0 the weight is the stored `[8:0]` read as a 9-bit two's-complement value, and stored bits `[11:9]` are ignored. With `WMODE` = 1 the stored 12 bits are unsigned.
- R4: Accumulation saturates at +8388607 and −8388608 instead of wrapping.
- R5: An event with magnitude zero leaves the target's state unchanged.
- R6: A `tick` accepted while `in_ready` is 1 drops `in_ready` from the next cycle until the sweep ends. Events already queued are applied before any neuron is evaluated. A `tick` at any other time is ignored.
- R7: In the sweep, a neuron fires when its threshold is non-zero and its state is non-negative and at least the threshold. The emitted value is floor(state / threshold), limited to 4095. Value × threshold is subtracted from the state.
- R8: Each firing gives a one-cycle `out_valid` pulse. The packet is `[11:0]` value, `[21:12]` neuron index (zero-extended) and `[31:22]` zero. Within one sweep the pulses come in ascending neuron order.
- R9: A neuron with a zero threshold or a negative state never fires.
- R10: A configuration write with `cfg_we` = 1 selects its target by `cfg_sel`. Code 0 writes the weight at `cfg_addr` from `cfg_data[11:0]`. Code 1 writes the threshold of neuron `cfg_addr` from `cfg_data[23:0]`. Code 2 writes the fan-in base of neuron `cfg_addr` from `cfg_data[WADDR_W-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming event present |
| in_ready | output | 1 | Event accepted when high together with `in_valid` |
| in_pkt | input | 32 | Incoming event packet |
| tick | input | 1 | Timestep strobe that starts the update sweep |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration target: 0 weight, 1 threshold, 2 fan-in base |
| cfg_addr | input | CFG_AW | Weight address or neuron index |
| cfg_data | input | 24 | Configuration write data |
| out_valid | output | 1 | Outgoing spike packet valid (one cycle) |
| out_pkt | output | 32 | Outgoing graded spike packet |

## Verification
The assertions assume that configuration writes happen only while the event FIFO is empty and no sweep is running. They also assume that `tick` is raised only while `in_ready` is high, so that one sweep never follows another straight away. The bench follows both rules. It configures only after a full sweep window has passed. It strobes only from the idle state, and it offers events only after it has seen `in_ready` high. Random magnitudes, weights, bases and thresholds are mixed with directed cases that push the state into both saturation limits, send zero-magnitude events and load weights with their unused upper bits set.

// File: rtl/spike_accum_pkg.sv
// Package: shared types and constants for the graded spike accumulate-and-fire unit.
// Assumes: the 32-bit event layout and the 24-bit state width are fixed for the core.
package spike_accum_pkg;

    localparam int STATE_W = 24;
    localparam int SPIKE_W = 12;
    localparam int PKT_W   = 32;

    localparam logic signed [STATE_W-1:0] STATE_MAX = 24'sh7FFFFF;
    localparam logic signed [STATE_W-1:0] STATE_MIN = -24'sh800000;

    localparam logic [1:0] CFG_WEIGHT = 2'd0;
    localparam logic [1:0] CFG_THRESH = 2'd1;
    localparam logic [1:0] CFG_BASE   = 2'd2;

    typedef enum logic [1:0] {
        PH_ACCUM  = 2'd0,
        PH_DRAIN  = 2'd1,
        PH_UPDATE = 2'd2
    } phase_t;

endpackage

// File: rtl/spike_evt_fifo.sv
// Module: small show-ahead event FIFO.
// Assumes: the caller never pushes when full and never pops when empty.
module spike_evt_fifo #(
    parameter int W  = 32,
    parameter int AW = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    // Storage write; no reset needed for payload.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + AW'(1);
            if (pop)  rp <= rp + AW'(1);
            case ({push, pop})
                2'b10:   cnt <= cnt + (AW+1)'(1);
                2'b01:   cnt <= cnt - (AW+1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign dout  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == (AW+1)'(DEPTH));
endmodule

// File: rtl/spike_accum_dp.sv
// Module: weighted-spike accumulate datapath (combinational).
// Assumes: weight is stored as 12 raw bits; WMODE 0 reads [8:0] signed, 1 reads all 12 unsigned.
module spike_accum_dp
    import spike_accum_pkg::*;
#(
    parameter int WMODE = 0
) (
    input  logic signed [STATE_W-1:0] state_in,
    input  logic        [SPIKE_W-1:0] spike,
    input  logic        [11:0]        wraw,
    output logic signed [STATE_W-1:0] state_out
);
    logic signed [12:0] w_ext;

    // Weight interpretation picked by parameter.
    generate
        if (WMODE == 0) begin : g_signed9
            logic [2:0] unused_whi;
            assign unused_whi = wraw[11:9];
            assign w_ext = {{4{wraw[8]}}, wraw[8:0]};
        end else begin : g_unsigned12
            assign w_ext = {1'b0, wraw};
        end
    endgenerate

    logic signed [25:0] prod;
    logic signed [26:0] sum;

    assign prod = $signed({1'b0, spike}) * w_ext;
    assign sum  = {{3{state_in[STATE_W-1]}}, state_in} + {prod[25], prod};

    // Clamp the sum into the signed state range.
    always_comb begin
        if (sum > 27'sd8388607)       state_out = STATE_MAX;
        else if (sum < -27'sd8388608) state_out = STATE_MIN;
        else                          state_out = sum[STATE_W-1:0];
    end
endmodule

// File: rtl/spike_fire_unit.sv
// Module: threshold test, graded spike value and residue (combinational).
// Assumes: threshold zero means the neuron is disabled.
module spike_fire_unit
    import spike_accum_pkg::*;
(
    input  logic signed [STATE_W-1:0] state,
    input  logic        [STATE_W-1:0] thr,
    output logic                      fire,
    output logic        [SPIKE_W-1:0] value,
    output logic signed [STATE_W-1:0] residue
);
    logic [STATE_W-1:0] st_u, divisor, quot, spent;

    assign st_u    = state;
    assign divisor = (thr == '0) ? 24'd1 : thr;
    assign quot    = st_u / divisor;
    assign fire    = (thr != '0) && !state[STATE_W-1] && (st_u >= thr);

    // Saturate the quotient into the 12-bit payload.
    always_comb begin
        if (quot > 24'd4095) value = 12'hFFF;
        else                 value = quot[SPIKE_W-1:0];
    end

    assign spent   = {12'b0, value} * thr;
    assign residue = fire ? (state - $signed(spent)) : state;
endmodule

// File: rtl/spike_accum_core.sv
// Module: graded spike accumulate-and-fire core (top).
// Assumes: ID_W <= 10; configuration is written only while idle with an empty FIFO.
module spike_accum_core
    import spike_accum_pkg::*;
#(
    parameter int ID_W    = 6,
    parameter int WADDR_W = 8,
    parameter int FIFO_AW = 2,
    parameter int WMODE   = 0,
    parameter int CFG_AW  = (WADDR_W > ID_W) ? WADDR_W : ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_pkt,
    input  logic              tick,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [23:0]       cfg_data,
    output logic              out_valid,
    output logic [31:0]       out_pkt
);
    localparam int NEURONS = 1 << ID_W;
    localparam int WDEPTH  = 1 << WADDR_W;

    logic signed [STATE_W-1:0] state_mem [NEURONS];
    logic        [STATE_W-1:0] thr_mem   [NEURONS];
    logic        [WADDR_W-1:0] base_mem  [NEURONS];
    logic        [11:0]        wt_mem    [WDEPTH];

    phase_t          phase;
    logic [ID_W-1:0] idx;

    logic              push, pop, empty, full;
    logic [PKT_W-1:0]  head;
    logic [SPIKE_W-1:0] h_val;
    logic [ID_W-1:0]   h_dst;
    logic [9:0]        h_src;
    logic [WADDR_W-1:0] waddr;

    assign in_ready = (phase == PH_ACCUM) && !full;
    assign push     = in_valid && in_ready;
    assign pop      = (phase != PH_UPDATE) && !empty;

    spike_evt_fifo #(.W(PKT_W), .AW(FIFO_AW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(in_pkt),
        .pop(pop), .dout(head), .empty(empty), .full(full)
    );

    assign h_val = head[11:0];
    assign h_dst = head[12 +: ID_W];
    assign h_src = head[31:22];
    assign waddr = base_mem[h_dst] + WADDR_W'(h_src);

    generate
        if (ID_W < 10) begin : g_id_pad
            logic [9-ID_W:0] unused_idhi;
            assign unused_idhi = head[21:12+ID_W];
        end
    endgenerate

    logic signed [STATE_W-1:0] acc_out;
    spike_accum_dp #(.WMODE(WMODE)) u_dp (
        .state_in(state_mem[h_dst]), .spike(h_val),
        .wraw(wt_mem[waddr]), .state_out(acc_out)
    );

    logic                      fire;
    logic [SPIKE_W-1:0]        fval;
    logic signed [STATE_W-1:0] residue;
    spike_fire_unit u_fire (
        .state(state_mem[idx]), .thr(thr_mem[idx]),
        .fire(fire), .value(fval), .residue(residue)
    );

    // Phase sequencing: accumulate, drain on strobe, then sweep all neurons.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_ACCUM;
            idx   <= '0;
        end else begin
            case (phase)
                PH_ACCUM: if (tick) phase <= PH_DRAIN;
                PH_DRAIN: if (empty) begin
                    phase <= PH_UPDATE;
                    idx   <= '0;
                end
                PH_UPDATE: begin
                    idx <= idx + ID_W'(1);
                    if (&idx) phase <= PH_ACCUM;
                end
                default: phase <= PH_ACCUM;
            endcase
        end
    end

    // Membrane state: event accumulation or post-fire residue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NEURONS; i++) state_mem[i] <= '0;
        end else if (pop) begin
            state_mem[h_dst] <= acc_out;
        end else if (phase == PH_UPDATE && fire) begin
            state_mem[idx] <= residue;
        end
    end

    // Configuration writes for thresholds and fan-in bases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NEURONS; i++) begin
                thr_mem[i]  <= '0;
                base_mem[i] <= '0;
            end
        end else if (cfg_we) begin
            if (cfg_sel == CFG_THRESH) thr_mem[cfg_addr[ID_W-1:0]] <= cfg_data;
            if (cfg_sel == CFG_BASE)   base_mem[cfg_addr[ID_W-1:0]] <= cfg_data[WADDR_W-1:0];
        end
    end

    // Configuration writes for synaptic weights.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WDEPTH; i++) wt_mem[i] <= '0;
        end else if (cfg_we && cfg_sel == CFG_WEIGHT) begin
            wt_mem[cfg_addr[WADDR_W-1:0]] <= cfg_data[11:0];
        end
    end

    // Registered outgoing spike packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pkt   <= '0;
        end else begin
            out_valid <= (phase == PH_UPDATE) && fire;
            out_pkt   <= {10'b0, 10'(idx), fval};
        end
    end
endmodule

// File: rtl/spike_accum_chk.sv
// Module: port-level property checker, bound to the accumulate-and-fire core.
// Assumes: tick is raised only while in_ready is high.
module spike_accum_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        in_ready,
    input logic        out_valid,
    input logic [31:0] out_pkt
);
    AST_OUT_VALUE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_pkt[11:0] != 12'd0); // R7

    AST_OUT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_pkt[31:22] == 10'd0); // R8

    AST_OUT_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> out_pkt[21:12] > $past(out_pkt[21:12])); // R8

    AST_TICK_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && in_ready) |=> !in_ready); // R6

    AST_FIRE_WHILE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(!in_ready)); // R6
endmodule

bind spike_accum_core spike_accum_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_ready(in_ready),
    .out_valid(out_valid), .out_pkt(out_pkt)
);

// File: tb/sim_spike_accum_core.sv
// Bench: random and directed events checked against a behavioural neuron model.
module sim_spike_accum_core;
    localparam int NN = 64;
    localparam int WD = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_pkt = '0;
    logic        tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_addr = '0;
    logic [23:0] cfg_data = '0;
    logic        out_valid;
    logic [31:0] out_pkt;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    longint m_st [NN];
    longint m_thr[NN];
    int     m_base[NN];
    int     m_wt [WD];

    spike_accum_core u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pkt(in_pkt), .tick(tick), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .out_valid(out_valid),
        .out_pkt(out_pkt)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint wsext(input int raw);
        int b = raw & 511;
        return (b >= 256) ? longint'(b - 512) : longint'(b);
    endfunction

    function automatic longint sat24(input longint v);
        if (v > 8388607)  return 8388607;
        if (v < -8388608) return -8388608;
        return v;
    endfunction

    task automatic cfg(input int sel, input int addr, input int data);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_addr = 8'(addr); cfg_data = 24'(data);
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 0) m_wt[addr]   = data & 12'hFFF;
        if (sel == 1) m_thr[addr]  = data & 24'hFFFFFF;
        if (sel == 2) m_base[addr] = data & (WD - 1);
    endtask

    task automatic send(input int dst, input int src, input int val);
        int addr;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_pkt = {10'(src), 10'(dst), 12'(val)};
        @(negedge clk);
        in_valid = 1'b0;
        addr = (m_base[dst] + src) % WD;
        m_st[dst] = sat24(m_st[dst] + longint'(val) * wsext(m_wt[addr]));
    endtask

    task automatic run_tick(input string req);
        logic [31:0] exp_q[$];
        logic [31:0] act_q[$];
        int n_cmp;
        for (int n = 0; n < NN; n++) begin
            if (m_thr[n] != 0 && m_st[n] >= m_thr[n]) begin
                longint q = m_st[n] / m_thr[n];
                if (q > 4095) q = 4095;
                m_st[n] -= q * m_thr[n];
                exp_q.push_back({10'd0, 10'(n), 12'(q)});
            end
        end
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk(in_ready == 1'b0, "R6", longint'(in_ready), 0);
        repeat (80) begin
            @(negedge clk);
            if (out_valid) act_q.push_back(out_pkt);
        end
        chk(act_q.size() == exp_q.size(), req, act_q.size(), exp_q.size());
        n_cmp = (act_q.size() < exp_q.size()) ? act_q.size() : exp_q.size();
        for (int i = 0; i < n_cmp; i++)
            chk(act_q[i] == exp_q[i], req, longint'(act_q[i]), longint'(exp_q[i]));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < NN; i++) begin m_st[i] = 0; m_thr[i] = 0; m_base[i] = 0; end
        for (int i = 0; i < WD; i++) m_wt[i] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        chk(in_ready == 1'b1, "R1", longint'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        run_tick("R1");

        // R10: load full configuration
        for (int a = 0; a < WD; a++) cfg(0, a, int'($urandom_range(0, 4095)));
        for (int n = 0; n < NN; n++) begin
            cfg(1, n, ($urandom_range(0, 5) == 0) ? 0 : int'($urandom_range(1, 1 << 18)));
            cfg(2, n, int'($urandom_range(0, WD - 1)));
        end

        // R2: random event rounds
        for (int r = 0; r < 6; r++) begin
            for (int e = 0; e < 40; e++) begin
                int v = ($urandom_range(0, 7) == 0) ? 0 : int'($urandom_range(1, 4095));
                send(int'($urandom_range(0, NN - 1)), int'($urandom_range(0, 1023)), v);
            end
            run_tick("R2");
        end

        // R4: positive saturation, then R7 value limit
        cfg(1, 5, 0);
        cfg(0, (m_base[5] + 0) % WD, 255);
        for (int k = 0; k < 10; k++) send(5, 0, 4095);
        run_tick("R4");
        cfg(1, 5, 1);
        run_tick("R7");

        // R9: negative saturation never fires
        cfg(1, 11, 1);
        cfg(0, (m_base[11] + 7) % WD, 12'h100);
        for (int k = 0; k < 10; k++) send(11, 7, 4095);
        run_tick("R9");

        // R5: zero-magnitude events with a large weight
        cfg(1, 9, 1);
        cfg(0, (m_base[9] + 2) % WD, 200);
        for (int k = 0; k < 8; k++) send(9, 2, 0);
        run_tick("R5");

        // R3: upper weight bits ignored, 9-bit sign honoured
        cfg(1, 20, 1);
        cfg(0, (m_base[20] + 3) % WD, 12'hFFF);
        for (int k = 0; k < 5; k++) send(20, 3, 100);
        run_tick("R3");
        cfg(0, (m_base[20] + 3) % WD, 12'hEFF);
        send(20, 3, 4000);
        run_tick("R3");

        // R8: many small thresholds fire in order
        for (int n = 0; n < NN; n += 3) cfg(1, n, int'($urandom_range(1, 64)));
        for (int e = 0; e < 50; e++)
            send(int'($urandom_range(0, NN - 1)), int'($urandom_range(0, 1023)),
                 int'($urandom_range(1, 4095)));
        run_tick("R8");

        done = 1;
        summary();
        $finish;
    end
endmodule